// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Flags

This block takes an asynchronous serial line that idles high and turns each character frame into a byte. A frame is one start bit, eight data bits sent least significant bit first, and one or two stop bits. The line is resynchronised to the core clock. It is then sampled on a single-cycle enable that pulses sixteen times per bit period. Finished bytes go into a receive holding register. A status register carries a holding-full flag and two error flags.

Software reaches the block through a small register port with a two-bit address, separate read and write strobes and combinational read data. Each flag clears through a handshake: software first reads the status register while the flag is 1, then writes 0 to that bit. The two error flags are sticky and stop reception until software clears them. A framing error still places the received byte in the holding register, but it leaves the full flag unchanged.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, reading address 0 (data), address 1 (status) and address 2 (control) each returns 0x00. The receiver starts disabled and set for one stop bit.
- R2: When the control enable bit (address 2, bit 0) is 1, a frame is accepted as follows: a falling edge on the idle-high line, the line still low eight oversample ticks later, then eight data bits sampled every sixteen ticks with the least significant bit first. If that frame has a high stop bit and the full flag (status bit 0) is 0, the byte is loaded into the data register and the full flag is set.
- R3: If the line is back high at the mid-start sample, the frame is dropped. Nothing is loaded and no flag changes.
- R4: A stop bit sampled low sets the framing flag (status bit 1 is unaffected, status bit 2 is set). The byte is still written to the data register, and the full flag keeps its previous value. This holds whatever the full flag's state is.
- R5: With control bit 1 set, two stop bits are expected. Only the first is sampled, and a low second stop bit causes no error.
- R6: A frame that completes with a high stop bit while the full flag is 1 sets the overrun flag (status bit 1). The data register keeps the older byte.
- R7: While the overrun flag or the framing flag is 1, no frame is received. The data register and the full flag stay unchanged until both error flags are cleared.
- R8: A status flag clears only when a write to address 1 has a 0 in that bit and a status read has earlier returned that bit as 1. A write of 0 with no such read does nothing. Writing 1 never sets a flag.
- R9: Writing 0 to the control enable bit leaves every status flag unchanged. No frame is received while the enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, one pulse per sixteenth of a bit |
| rxd_i | input | 1 | Serial input line, idle high |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |

## Verification
The embedded properties assume three things about the inputs. The read and write strobes are never high in the same cycle. The oversampling enable is a single-cycle pulse. Software never writes the status register in the same cycle that a frame finishes.

The stimulus keeps within these limits. It runs the enable at one pulse every four clocks. It holds each serial bit for exactly sixteen ticks. It makes register accesses only while the line is idle, after each frame has fully settled.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;
    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int unsigned ST_FULL = 0;
    localparam int unsigned ST_OVR  = 1;
    localparam int unsigned ST_FER  = 2;

    localparam int unsigned CT_EN   = 0;
    localparam int unsigned CT_TWO  = 1;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_STOP2
    } rx_state_e;
endpackage

// File: rtl/srx_line_sync.sv
`timescale 1ns/1ps
module srx_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/srx_frame_fsm.sv
`timescale 1ns/1ps
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              run,
    input  logic              two_stop,
    output logic              done,
    output logic [DATA_W-1:0] done_byte,
    output logic              stop_ok
);
    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              prev;
        logic              done;
        logic              stop_ok;
    } fsm_t;

    localparam fsm_t FSM_RST = '{state: RX_IDLE, cnt: '0, idx: '0,
                                 shreg: '0, prev: 1'b1, done: 1'b0, stop_ok: 1'b0};

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        if (tick) begin
            fsm_d.prev = line;
            unique case (fsm_q.state)
                RX_IDLE: begin
                    if (fsm_q.prev && !line) begin
                        fsm_d.state = RX_START;
                        fsm_d.cnt   = '0;
                    end
                end
                RX_START: begin
                    if (fsm_q.cnt == CNT_MID) begin
                        fsm_d.cnt = '0;
                        fsm_d.idx = '0;
                        fsm_d.state = line ? RX_IDLE : RX_DATA;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (fsm_q.cnt == CNT_LAST) begin
                        fsm_d.cnt   = '0;
                        fsm_d.shreg = {line, fsm_q.shreg[DATA_W-1:1]};
                        if (fsm_q.idx == IDX_LAST) fsm_d.state = RX_STOP;
                        else                       fsm_d.idx   = fsm_q.idx + 1'b1;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (fsm_q.cnt == CNT_LAST) begin
                        fsm_d.cnt     = '0;
                        fsm_d.done    = 1'b1;
                        fsm_d.stop_ok = line;
                        fsm_d.state   = two_stop ? RX_STOP2 : RX_IDLE;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                RX_STOP2: begin
                    if (fsm_q.cnt == CNT_LAST) begin
                        fsm_d.cnt   = '0;
                        fsm_d.state = RX_IDLE;
                    end else begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end
                end
                default: fsm_d.state = RX_IDLE;
            endcase
        end
        if (!run) begin
            fsm_d.state = RX_IDLE;
            fsm_d.cnt   = '0;
            fsm_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= FSM_RST;
        else        fsm_q <= fsm_d;
    end

    assign done      = fsm_q.done;
    assign done_byte = fsm_q.shreg;
    assign stop_ok   = fsm_q.stop_ok;

    // R2: each finished frame is reported by a single-cycle pulse
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.done |=> !fsm_q.done);
endmodule

// File: rtl/srx_regfile.sv
`timescale 1ns/1ps
module srx_regfile
    import srx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fr_done,
    input  logic [DATA_W-1:0] fr_byte,
    input  logic              fr_stop_ok,
    output logic              rx_en,
    output logic              two_stop,
    output logic              flag_err
);
    typedef struct packed {
        logic [DATA_W-1:0] rdr;
        logic              full;
        logic              ovr;
        logic              fer;
        logic              arm_full;
        logic              arm_ovr;
        logic              arm_fer;
        logic              en;
        logic              two;
    } regs_t;

    regs_t regs_d, regs_q;

    logic rd_stat, wr_stat, wr_ctrl;
    assign rd_stat = bus_rd && (bus_addr == ADDR_STAT);
    assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[DATA_W-1:3];

    always_comb begin
        regs_d = regs_q;
        if (rd_stat) begin
            if (regs_q.full) regs_d.arm_full = 1'b1;
            if (regs_q.ovr)  regs_d.arm_ovr  = 1'b1;
            if (regs_q.fer)  regs_d.arm_fer  = 1'b1;
        end
        if (wr_stat) begin
            if (regs_q.arm_full && !bus_wdata[ST_FULL]) begin
                regs_d.full = 1'b0; regs_d.arm_full = 1'b0;
            end
            if (regs_q.arm_ovr && !bus_wdata[ST_OVR]) begin
                regs_d.ovr = 1'b0; regs_d.arm_ovr = 1'b0;
            end
            if (regs_q.arm_fer && !bus_wdata[ST_FER]) begin
                regs_d.fer = 1'b0; regs_d.arm_fer = 1'b0;
            end
        end
        if (wr_ctrl) begin
            regs_d.en  = bus_wdata[CT_EN];
            regs_d.two = bus_wdata[CT_TWO];
        end
        if (fr_done) begin
            if (!fr_stop_ok) begin
                regs_d.fer = 1'b1;
                regs_d.rdr = fr_byte;
            end else if (regs_d.full) begin
                regs_d.ovr = 1'b1;
            end else begin
                regs_d.full = 1'b1;
                regs_d.rdr  = fr_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = regs_q.rdr;
            ADDR_STAT: begin
                bus_rdata[ST_FULL] = regs_q.full;
                bus_rdata[ST_OVR]  = regs_q.ovr;
                bus_rdata[ST_FER]  = regs_q.fer;
            end
            ADDR_CTRL: begin
                bus_rdata[CT_EN]  = regs_q.en;
                bus_rdata[CT_TWO] = regs_q.two;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign rx_en    = regs_q.en;
    assign two_stop = regs_q.two;
    assign flag_err = regs_q.ovr | regs_q.fer;

    // R6: the older byte survives an overrun
    assert_ovr_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q.ovr) |-> $stable(regs_q.rdr));
    // R4: framing flag only follows a low stop bit
    assert_fer_from_bad_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q.fer) |-> $past(fr_done && !fr_stop_ok));
    // R8: overrun flag drops only on a status write with that bit 0
    assert_ovr_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(regs_q.ovr) |-> $past(wr_stat && !bus_wdata[ST_OVR]));
    // R8: framing flag drops only on a status write with that bit 0
    assert_fer_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(regs_q.fer) |-> $past(wr_stat && !bus_wdata[ST_FER]));
endmodule

// File: rtl/serial_rx_core.sv
`timescale 1ns/1ps
module serial_rx_core #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd_i,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              line_s;
    logic              fr_done, fr_stop_ok;
    logic [DATA_W-1:0] fr_byte;
    logic              rx_en, two_stop, flag_err, run;

    assign run = rx_en && !flag_err;

    srx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd_i),
        .dout (line_s)
    );

    srx_frame_fsm #(.DATA_W(DATA_W), .OSR(OSR)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .line     (line_s),
        .run      (run),
        .two_stop (two_stop),
        .done     (fr_done),
        .done_byte(fr_byte),
        .stop_ok  (fr_stop_ok)
    );

    srx_regfile #(.DATA_W(DATA_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .fr_done   (fr_done),
        .fr_byte   (fr_byte),
        .fr_stop_ok(fr_stop_ok),
        .rx_en     (rx_en),
        .two_stop  (two_stop),
        .flag_err  (flag_err)
    );

    // R7: no frame is delivered while an error flag is pending
    assert_stall_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_err |-> !fr_done);
endmodule

// File: tb/serial_rx_core_tb_top.sv
`timescale 1ns/1ps
module serial_rx_core_tb_top;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = TICK_DIV * 16;
    localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_CTRL = 2'd2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    serial_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_i(rxd),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            os_tick = (cnt == 0);
            cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
        end
    end

    typedef struct packed {
        logic [7:0] data;
        logic       two;
        logic       s1;
        logic       s2;
        logic       fer;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'hA5, 1'b0, 1'b1, 1'b1, 1'b0},
        '{8'h00, 1'b0, 1'b1, 1'b1, 1'b0},
        '{8'hFF, 1'b0, 1'b1, 1'b1, 1'b0},
        '{8'h3C, 1'b0, 1'b0, 1'b1, 1'b1},
        '{8'h81, 1'b1, 1'b1, 1'b0, 1'b0},
        '{8'h5A, 1'b1, 1'b0, 1'b1, 1'b1},
        '{8'h01, 1'b0, 1'b1, 1'b1, 1'b0},
        '{8'h80, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic hold_bit(input logic b);
        @(negedge clk);
        rxd = b;
        repeat (BIT_CLKS - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic two, input logic s1, input logic s2);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        hold_bit(s1);
        if (two) hold_bit(s2);
        @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic clear_all();
        logic [7:0] tmp;
        bus_read(A_STAT, tmp);
        bus_write(A_STAT, 8'h00);
    endtask

    initial begin
        logic [7:0] rv;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset contents
        bus_read(A_DATA, rv); check("R1 data", rv, 8'h00);
        bus_read(A_STAT, rv); check("R1 status", rv, 8'h00);
        bus_read(A_CTRL, rv); check("R1 control", rv, 8'h00);

        // vector table: R2 normal, R4 framing, R5 two stop bits
        for (int v = 0; v < 8; v++) begin
            string req;
            req = VECS[v].two ? "R5" : (VECS[v].fer ? "R4" : "R2");
            clear_all();
            bus_write(A_CTRL, {6'b0, VECS[v].two, 1'b1});
            send_frame(VECS[v].data, VECS[v].two, VECS[v].s1, VECS[v].s2);
            bus_read(A_DATA, rv); check(req, rv, VECS[v].data);
            bus_read(A_STAT, rv);
            check(req, {7'b0, rv[0]}, {7'b0, !VECS[v].fer});
            check(req, {7'b0, rv[1]}, 8'h00);
            check(req, {7'b0, rv[2]}, {7'b0, VECS[v].fer});
        end

        // R6 overrun, R8 clear handshake, R7 stall
        clear_all();
        bus_write(A_CTRL, 8'h01);
        send_frame(8'h11, 1'b0, 1'b1, 1'b1);
        send_frame(8'h22, 1'b0, 1'b1, 1'b1);
        bus_read(A_DATA, rv); check("R6 older byte kept", rv, 8'h11);
        bus_write(A_STAT, 8'h00);
        bus_read(A_STAT, rv); check("R8 write without read", rv, 8'h03);
        send_frame(8'h33, 1'b0, 1'b1, 1'b1);
        bus_read(A_DATA, rv); check("R7 stalled data", rv, 8'h11);
        bus_read(A_STAT, rv); check("R7 stalled status", rv, 8'h03);
        bus_write(A_STAT, 8'hFF);
        bus_read(A_STAT, rv); check("R8 write one", rv, 8'h03);
        bus_write(A_STAT, 8'h00);
        bus_read(A_STAT, rv); check("R8 cleared", rv, 8'h00);
        send_frame(8'h44, 1'b0, 1'b1, 1'b1);
        bus_read(A_DATA, rv); check("R7 resumed data", rv, 8'h44);
        bus_read(A_STAT, rv); check("R7 resumed status", rv, 8'h01);

        // R9 disabling keeps flags and blocks frames
        clear_all();
        send_frame(8'h6B, 1'b0, 1'b0, 1'b1);
        bus_write(A_CTRL, 8'h00);
        bus_read(A_STAT, rv); check("R9 flag kept", rv, 8'h04);
        bus_read(A_DATA, rv); check("R4 byte loaded", rv, 8'h6B);
        bus_write(A_STAT, 8'h00);
        bus_read(A_STAT, rv); check("R8 fer cleared", rv, 8'h00);
        send_frame(8'h77, 1'b0, 1'b1, 1'b1);
        bus_read(A_STAT, rv); check("R9 disabled status", rv, 8'h00);
        bus_read(A_DATA, rv); check("R9 disabled data", rv, 8'h6B);
        bus_write(A_CTRL, 8'h01);
        send_frame(8'h78, 1'b0, 1'b1, 1'b1);
        bus_read(A_DATA, rv); check("R9 reenabled", rv, 8'h78);

        // R3 short low pulse is not a start bit
        clear_all();
        @(negedge clk); rxd = 1'b0;
        repeat (6 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        bus_read(A_STAT, rv); check("R3 glitch status", rv, 8'h00);
        bus_read(A_DATA, rv); check("R3 glitch data", rv, 8'h78);
        send_frame(8'h9C, 1'b0, 1'b1, 1'b1);
        bus_read(A_DATA, rv); check("R3 after glitch", rv, 8'h9C);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule